// File: doc/BRIEF.md
# Translation Fault Recorder

This block keeps the record that software inspects after a memory-translation fault. Each time the page-table walker reports a fault, the recorder builds a status word from the fault code and the access index. It also latches the page-aligned faulting virtual address and selects between the instruction-access trap and the data-access trap. If a second fault arrives before software has read and cleared the first, the recorder keeps only the newest fault fields and sets an overflow flag.

The status word has fixed bit positions. Bit 0 is the overflow flag and bit 1 is the valid flag. The access index occupies bits starting at bit 5. The fault code is ORed in from bit 2 upward. A software read strobe clears the status word. A misaligned-access strobe bypasses translation and loads only the address register.

A three-state controller tracks the status word:
- `ST_EMPTY`: nothing is recorded.
- `ST_SINGLE`: one fault is recorded and unread.
- `ST_OVERRUN`: a fault arrived while another was unread.

The controller has these transitions:
- `T_FIRST`: a fault in `ST_EMPTY`, or a fault in any state together with a read, goes to `ST_SINGLE`.
- `T_PILEUP`: a fault in `ST_SINGLE` or `ST_OVERRUN` with no read goes to `ST_OVERRUN`.
- `T_DRAIN`: a read with no fault goes to `ST_EMPTY`.
- `T_HOLD`: with no fault and no read, the state stays as it is.

All outputs are registered and change on the clock edge that samples the strobe.

Top module: `fault_recorder`

## Requirements
- R1: After reset the status word, the address register and the trap select are all zero.
- R2: A fault while the status word is zero sets the status word to (access index << 5) | (code with bits 1:0 cleared) | 2, with bit 0 clear.
- R3: A fault while the status word is nonzero, with no read in that cycle, discards the earlier fields. The status word becomes 1 | (access index << 5) | code | 2.
- R4: Every fault loads the address register with the fault address with its low PAGE_BITS bits forced to zero.
- R5: A read with no fault in that cycle clears the status word to zero and leaves the address register and the trap select unchanged.
- R6: A fault and a read in the same cycle record the fault as a non-overflow fault, using the R2 value.
- R7: On each fault the trap select becomes access-index bit 1, where 1 means an instruction fetch and selects the instruction-access trap, and 0 selects the data-access trap. Between faults the trap select holds its value.
- R8: A misaligned strobe with no fault loads the full, unmasked misaligned address into the address register and leaves the status word unchanged. A fault in the same cycle takes precedence.
- R9: With no strobe and no read, all three registers hold their values.
- R10: Bits 1:0 of the fault code input have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_stb | input | 1 | Fault reported by the walker |
| flt_code | input | CODE_W | Fault type and level code |
| flt_acc | input | ACC_W | Access index (bit 2 write, bit 1 fetch, bit 0 supervisor) |
| flt_addr | input | ADDR_W | Faulting virtual address |
| mis_stb | input | 1 | Misaligned access reported |
| mis_addr | input | ADDR_W | Misaligned address |
| rd_clr | input | 1 | Software read of the status word, which clears it |
| fsr_q | output | FSR_W | Fault status word |
| far_q | output | ADDR_W | Fault address register |
| trap_instr | output | 1 | 1 selects the instruction-access trap, 0 the data-access trap |

## Verification
The bench builds the block with its defaults: a 32-bit address, 12 page bits, a 10-bit code and a 3-bit access index in a 16-bit status word. With 12 page bits, the low address bits that a fault must clear and a misaligned strobe must keep are large enough to be seen. With a 10-bit code, the level bits at 9:8 and the code bits that overlap the access-index field at 7:5 are both exercised. The stimulus drives repeated faults without reads, simultaneous faults and reads, reads of an empty word, and misaligned strobes alone and colliding with faults.

// File: rtl/fault_recorder_pkg.sv
package fault_recorder_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_SINGLE  = 2'd1,
        ST_OVERRUN = 2'd2
    } rec_state_t;

    typedef enum logic {
        TRAP_DATA  = 1'b0,
        TRAP_INSTR = 1'b1
    } trap_kind_t;

    localparam int OVF_BIT   = 0;
    localparam int VALID_BIT = 1;
    localparam int ACC_SHIFT = 5;
    localparam int FETCH_BIT = 1;
endpackage

// File: rtl/fault_recorder_ctrl.sv
module fault_recorder_ctrl
    import fault_recorder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flt_stb,
    input  logic rd_clr,
    output logic load_o,
    output logic seed_ovf_o,
    output logic clear_o
);
    rec_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (flt_stb) state_d = ST_SINGLE;
            end
            ST_SINGLE, ST_OVERRUN: begin
                if (flt_stb && rd_clr)  state_d = ST_SINGLE;
                else if (flt_stb)       state_d = ST_OVERRUN;
                else if (rd_clr)        state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o     = flt_stb;
        seed_ovf_o = 1'b0;
        clear_o    = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                seed_ovf_o = 1'b0;
            end
            ST_SINGLE, ST_OVERRUN: begin
                seed_ovf_o = flt_stb && !rd_clr;
                clear_o    = rd_clr && !flt_stb;
            end
            default: begin
                clear_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fault_recorder_status.sv
module fault_recorder_status
    import fault_recorder_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int ACC_W  = 3,
    parameter int FSR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              seed_ovf_i,
    input  logic              clear_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [ACC_W-1:0]  acc_i,
    output logic [FSR_W-1:0]  fsr_o
);
    logic [FSR_W-1:0] merged;

    always_comb begin
        merged = '0;
        merged[CODE_W-1:2] = code_i[CODE_W-1:2];
        merged[ACC_SHIFT +: ACC_W] = merged[ACC_SHIFT +: ACC_W] | acc_i;
        merged[VALID_BIT] = 1'b1;
        merged[OVF_BIT]   = seed_ovf_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       fsr_o <= '0;
        else if (load_i)  fsr_o <= merged;
        else if (clear_i) fsr_o <= '0;
    end
endmodule

// File: rtl/fault_recorder_addr.sv
module fault_recorder_addr
    import fault_recorder_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int ACC_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_stb,
    input  logic [ACC_W-1:0]  flt_acc,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              mis_stb,
    input  logic [ADDR_W-1:0] mis_addr,
    output logic [ADDR_W-1:0] far_o,
    output logic              trap_instr_o
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    trap_kind_t kind_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            far_o  <= '0;
            kind_q <= TRAP_DATA;
        end else if (flt_stb) begin
            far_o  <= flt_addr & PAGE_MASK;
            kind_q <= flt_acc[FETCH_BIT] ? TRAP_INSTR : TRAP_DATA;
        end else if (mis_stb) begin
            far_o  <= mis_addr;
        end
    end

    assign trap_instr_o = (kind_q == TRAP_INSTR);
endmodule

// File: rtl/fault_recorder.sv
module fault_recorder #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int CODE_W    = 10,
    parameter int ACC_W     = 3,
    parameter int FSR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_stb,
    input  logic [CODE_W-1:0] flt_code,
    input  logic [ACC_W-1:0]  flt_acc,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              mis_stb,
    input  logic [ADDR_W-1:0] mis_addr,
    input  logic              rd_clr,
    output logic [FSR_W-1:0]  fsr_q,
    output logic [ADDR_W-1:0] far_q,
    output logic              trap_instr
);
    logic load, seed_ovf, clear;

    fault_recorder_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_stb    (flt_stb),
        .rd_clr     (rd_clr),
        .load_o     (load),
        .seed_ovf_o (seed_ovf),
        .clear_o    (clear)
    );

    fault_recorder_status #(.CODE_W(CODE_W), .ACC_W(ACC_W), .FSR_W(FSR_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .seed_ovf_i (seed_ovf),
        .clear_i    (clear),
        .code_i     (flt_code),
        .acc_i      (flt_acc),
        .fsr_o      (fsr_q)
    );

    fault_recorder_addr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ACC_W(ACC_W)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .flt_stb      (flt_stb),
        .flt_acc      (flt_acc),
        .flt_addr     (flt_addr),
        .mis_stb      (mis_stb),
        .mis_addr     (mis_addr),
        .far_o        (far_q),
        .trap_instr_o (trap_instr)
    );
endmodule

// File: rtl/fault_recorder_chk.sv
module fault_recorder_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int CODE_W    = 10,
    parameter int ACC_W     = 3,
    parameter int FSR_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_stb,
    input logic [CODE_W-1:0] flt_code,
    input logic [ACC_W-1:0]  flt_acc,
    input logic [ADDR_W-1:0] flt_addr,
    input logic              mis_stb,
    input logic [ADDR_W-1:0] mis_addr,
    input logic              rd_clr,
    input logic [FSR_W-1:0]  fsr_q,
    input logic [ADDR_W-1:0] far_q,
    input logic              trap_instr
);
    a_r3_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && !rd_clr && fsr_q != '0) |=> (fsr_q[0] && fsr_q[1]));

    a_r2_fresh_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && fsr_q == '0) |=> (!fsr_q[0] && fsr_q[1]));

    a_r6_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && rd_clr) |=> (!fsr_q[0] && fsr_q[1]));

    a_r4_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (far_q[PAGE_BITS-1:0] == '0));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !flt_stb) |=> (fsr_q == '0 && $stable(far_q) && $stable(trap_instr)));

    a_r7_trap_select: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (trap_instr == $past(flt_acc[1])));

    a_r8_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (mis_stb && !flt_stb) |=> (far_q == $past(mis_addr)));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_stb && !mis_stb && !rd_clr) |=> ($stable(fsr_q) && $stable(far_q) && $stable(trap_instr)));

    a_r10_low_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (fsr_q[4:2] == ($past(flt_code[4:2]) | {1'b0, 2'b00})));
endmodule

bind fault_recorder fault_recorder_chk #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CODE_W(CODE_W), .ACC_W(ACC_W), .FSR_W(FSR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_code(flt_code), .flt_acc(flt_acc),
    .flt_addr(flt_addr), .mis_stb(mis_stb), .mis_addr(mis_addr), .rd_clr(rd_clr),
    .fsr_q(fsr_q), .far_q(far_q), .trap_instr(trap_instr)
);

// File: tb/tb_fault_recorder.sv
`timescale 1ns/1ps
module tb_fault_recorder;
    localparam int ADDR_W = 32, PAGE_BITS = 12, CODE_W = 10, ACC_W = 3, FSR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flt_stb = 1'b0;
    logic [CODE_W-1:0] flt_code = '0;
    logic [ACC_W-1:0]  flt_acc = '0;
    logic [ADDR_W-1:0] flt_addr = '0;
    logic              mis_stb = 1'b0;
    logic [ADDR_W-1:0] mis_addr = '0;
    logic              rd_clr = 1'b0;
    logic [FSR_W-1:0]  fsr_q;
    logic [ADDR_W-1:0] far_q;
    logic              trap_instr;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [FSR_W-1:0]  m_fsr;
    logic [ADDR_W-1:0] m_far;
    logic              m_trap;

    always #2.5 clk = ~clk;

    fault_recorder #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .CODE_W(CODE_W),
                     .ACC_W(ACC_W), .FSR_W(FSR_W)) dut (
        .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_code(flt_code),
        .flt_acc(flt_acc), .flt_addr(flt_addr), .mis_stb(mis_stb),
        .mis_addr(mis_addr), .rd_clr(rd_clr), .fsr_q(fsr_q), .far_q(far_q),
        .trap_instr(trap_instr)
    );

    task automatic compare(input string req);
        checks += 3;
        if (fsr_q !== m_fsr) begin
            errors++;
            $display("FAIL %s fsr got %h expected %h", req, fsr_q, m_fsr);
        end
        if (far_q !== m_far) begin
            errors++;
            $display("FAIL %s far got %h expected %h", req, far_q, m_far);
        end
        if (trap_instr !== m_trap) begin
            errors++;
            $display("FAIL %s trap got %b expected %b", req, trap_instr, m_trap);
        end
    endtask

    task automatic step(input string req, input bit f, input logic [ACC_W-1:0] acc,
                        input logic [CODE_W-1:0] code, input logic [ADDR_W-1:0] fa,
                        input bit rc, input bit m, input logic [ADDR_W-1:0] ma);
        flt_stb = f; flt_acc = acc; flt_code = code; flt_addr = fa;
        rd_clr = rc; mis_stb = m; mis_addr = ma;
        if (f) begin
            logic [FSR_W-1:0] v;
            v = ((m_fsr != 0) && !rc) ? 16'd1 : 16'd0;
            v = v | (FSR_W'(acc) << 5) | (FSR_W'(code) & ~FSR_W'(3)) | 16'd2;
            m_fsr  = v;
            m_far  = (fa >> PAGE_BITS) << PAGE_BITS;
            m_trap = acc[1];
        end else begin
            if (rc) m_fsr = '0;
            if (m)  m_far = ma;
        end
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_fsr = '0; m_far = '0; m_trap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        // R2 first data fault, level 1 invalid code 0x104
        step("R2", 1, 3'b101, 10'h104, 32'h1234_5ABC, 0, 0, '0);
        step("R9", 0, '0, '0, '0, 0, 0, '0);
        // R5 read clears
        step("R5", 0, '0, '0, '0, 1, 0, '0);
        // R7 instruction fetch fault selects instruction trap
        step("R7", 1, 3'b011, 10'h310, 32'hFFFF_F001, 0, 0, '0);
        // R3 second fault without read -> overflow
        step("R3", 1, 3'b100, 10'h008, 32'h0000_3FFF, 0, 0, '0);
        // R3 third fault stays overflow
        step("R3", 1, 3'b000, 10'h20C, 32'hABCD_E123, 0, 0, '0);
        // R6 fault with read: non-overflow
        step("R6", 1, 3'b110, 10'h004, 32'h8000_0FFF, 1, 0, '0);
        // R8 misaligned alone
        step("R8", 0, '0, '0, '0, 0, 1, 32'h0000_1237);
        // R8 fault and misaligned together: fault wins
        step("R8", 1, 3'b001, 10'h00C, 32'h5555_5555, 0, 1, 32'h0000_0003);
        // R10 low code bits ignored
        step("R5", 0, '0, '0, '0, 1, 0, '0);
        step("R10", 1, 3'b000, 10'h003, 32'h0000_2000, 0, 0, '0);
        // R4 alignment with all-ones address
        step("R4", 1, 3'b111, 10'h3FC, 32'hFFFF_FFFF, 1, 0, '0);
        // R9 idle hold
        step("R9", 0, 3'b111, 10'h3FF, 32'h1111_1111, 0, 0, 32'h2222_2222);
        // R1 reset again
        rst_n = 1'b0;
        m_fsr = '0; m_far = '0; m_trap = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule